// File: doc/BRIEF.md
# Machine-Check Condition Pending and Masking Logic

This block gathers machine-check conditions reported by the error detectors of a processor and decides when a machine-check interruption is taken. Conditions come in two kinds. Exigent conditions need handling at once. Repressible conditions are sorted into subclasses, and each subclass has its own mask bit. Each repressible subclass has one sticky pending bit. Exigent conditions share one pending bit, and a separate bit records whether one of them was instruction-processing damage.

The global machine-check enable and the subclass masks come from the processor state. An instruction-boundary strobe and a machine-function-busy flag tell the block when a repressible interruption may be taken. When an interruption is taken, the block raises a one-cycle request with its kind and the condition field for the interruption code, and it clears what it reported. If instruction-processing damage is detected again while interruptions are still disabled after a damage interruption, the block enters check-stop.

Top module: `mc_cond_ctrl`

## Requirements
- R1: A repressible interruption is requested only when `glob_en_i` is 1 and at least one pending subclass has its bit in `sub_mask_i` set to 1. With `glob_en_i` at 0, no repressible request is made.
- R2: An exigent condition (`exig_cond_i` or `damage_i`) is requested whenever `glob_en_i` is 1. It ignores `sub_mask_i`, `insn_bound_i` and `mfunc_busy_i`. If `glob_en_i` is 0, the condition stays pending until the enable returns.
- R3: Each subclass holds at most one pending condition. Repeated pulses in that subclass give a single report. A masked subclass stays pending, for as long as it is masked, until it is enabled.
- R4: A repressible request is made only in a cycle where `insn_bound_i` is 1 and `mfunc_busy_i` is 0. Otherwise it waits.
- R5: A repressible request reports in `code_sub_o` every pending subclass, bit i for subclass i, including masked ones. All reported bits are then cleared.
- R6: When an exigent and a repressible request are eligible in the same cycle, the exigent one is taken first. An exigent request shows `mc_exig_o`=1, `suppress_o`=1 and `code_sub_o`=0, and it leaves the repressible bits pending. A repressible request shows `mc_exig_o`=0 and `suppress_o`=0.
- R7: A condition that arrives in the same cycle as the clear of its subclass stays pending and is reported again later.
- R8: If `damage_i` arrives while a damage interruption has been taken and `glob_en_i` is 0 and has not yet been restored, `chkstop_o` goes to 1 one cycle later. It stays at 1 until reset, and no request is made after that.
- R9: Outputs are registered. `mc_req_o` is 1 for the single cycle after the eligible cycle, `code_dmg_o` is 1 with an exigent request caused by damage, and every output is 0 during and after reset.
- R10: The damage guard releases once `glob_en_i` has been seen at 0 and then at 1 after the damage interruption. A later `damage_i` then becomes a new pending exigent condition, not a check-stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rep_cond_i | input | N_SUB | Repressible condition pulses, one per subclass |
| exig_cond_i | input | 1 | Exigent condition pulse (other than damage) |
| damage_i | input | 1 | Instruction-processing-damage pulse (exigent) |
| glob_en_i | input | 1 | Global machine-check enable |
| sub_mask_i | input | N_SUB | Per-subclass enable mask |
| insn_bound_i | input | 1 | Instruction-boundary strobe |
| mfunc_busy_i | input | 1 | Machine function in progress |
| mc_req_o | output | 1 | Interruption request, one-cycle pulse |
| mc_exig_o | output | 1 | Request kind: 1 exigent, 0 repressible |
| suppress_o | output | 1 | Suppress pending program and supervisor-call interruptions |
| code_sub_o | output | N_SUB | Reported repressible subclasses |
| code_dmg_o | output | 1 | Damage indicated in the code |
| chkstop_o | output | 1 | Check-stop state |

## Verification
A wrong pending bit shows up at the ports within two cycles. The subclass either appears in `code_sub_o` when it should not, or goes missing from it, on the next boundary where any enabled subclass fires. A full-mask drain then exposes a bit that was lost. A guard state that stays set too long, or clears too early, shows as a wrong `chkstop_o` one cycle after the next `damage_i`. The sweep covers every mask value against a distinct pending pattern, so errors in masking and clearing show up on the first mismatching combination.

// File: rtl/mc_cond_pkg.sv
package mc_cond_pkg;
  typedef enum logic {
    KIND_REP  = 1'b0,
    KIND_EXIG = 1'b1
  } mc_kind_e;
endpackage

// File: rtl/mc_pend_bank.sv
module mc_pend_bank #(
  parameter int N_SUB = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SUB-1:0] set_i,
  input  logic [N_SUB-1:0] clr_i,
  output logic [N_SUB-1:0] pend_o
);
  // one sticky latch per subclass; a set wins over a same-cycle clear
  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    always_ff @(posedge clk) begin
      if (rst)
        pend_o[g] <= 1'b0;
      else
        pend_o[g] <= set_i[g] | (pend_o[g] & ~clr_i[g]);
    end
  end
endmodule

// File: rtl/mc_dmg_guard.sv
module mc_dmg_guard (
  input  logic clk,
  input  logic rst,
  input  logic exig_cond_i,
  input  logic damage_i,
  input  logic glob_en_i,
  input  logic take_exig_i,
  output logic exig_pend_o,
  output logic dmg_pend_o,
  output logic chkstop_o
);
  logic armed_q;
  logic low_seen_q;
  logic stop_now;

  assign stop_now = damage_i & armed_q & ~glob_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      exig_pend_o <= 1'b0;
      dmg_pend_o  <= 1'b0;
      armed_q     <= 1'b0;
      low_seen_q  <= 1'b0;
      chkstop_o   <= 1'b0;
    end else begin
      exig_pend_o <= exig_cond_i | damage_i | (exig_pend_o & ~take_exig_i);
      dmg_pend_o  <= damage_i | (dmg_pend_o & ~take_exig_i);
      if (stop_now)
        chkstop_o <= 1'b1;
      if (take_exig_i && dmg_pend_o) begin
        armed_q    <= 1'b1;
        low_seen_q <= 1'b0;
      end else if (armed_q) begin
        if (!glob_en_i)
          low_seen_q <= 1'b1;
        else if (low_seen_q) begin
          armed_q    <= 1'b0;
          low_seen_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mc_req_arb.sv
module mc_req_arb
  import mc_cond_pkg::*;
#(
  parameter int N_SUB = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SUB-1:0] pend_i,
  input  logic [N_SUB-1:0] mask_i,
  input  logic             glob_en_i,
  input  logic             bound_i,
  input  logic             busy_i,
  input  logic             exig_pend_i,
  input  logic             dmg_pend_i,
  input  logic             stopped_i,
  output logic             take_exig_o,
  output logic [N_SUB-1:0] rep_clr_o,
  output logic             req_o,
  output logic             kind_o,
  output logic             suppress_o,
  output logic [N_SUB-1:0] code_sub_o,
  output logic             code_dmg_o
);
  logic take_rep;
  logic any_enabled;

  assign any_enabled = |(pend_i & mask_i);
  assign take_exig_o = glob_en_i & exig_pend_i & ~stopped_i;
  assign take_rep    = glob_en_i & any_enabled & bound_i & ~busy_i
                       & ~take_exig_o & ~stopped_i;
  assign rep_clr_o   = take_rep ? pend_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o      <= 1'b0;
      kind_o     <= KIND_REP;
      suppress_o <= 1'b0;
      code_sub_o <= '0;
      code_dmg_o <= 1'b0;
    end else begin
      req_o      <= take_exig_o | take_rep;
      kind_o     <= take_exig_o ? KIND_EXIG : KIND_REP;
      suppress_o <= take_exig_o;
      code_sub_o <= take_rep ? pend_i : '0;
      code_dmg_o <= take_exig_o & dmg_pend_i;
    end
  end
endmodule

// File: rtl/mc_cond_ctrl.sv
module mc_cond_ctrl #(
  parameter int N_SUB = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SUB-1:0] rep_cond_i,
  input  logic             exig_cond_i,
  input  logic             damage_i,
  input  logic             glob_en_i,
  input  logic [N_SUB-1:0] sub_mask_i,
  input  logic             insn_bound_i,
  input  logic             mfunc_busy_i,
  output logic             mc_req_o,
  output logic             mc_exig_o,
  output logic             suppress_o,
  output logic [N_SUB-1:0] code_sub_o,
  output logic             code_dmg_o,
  output logic             chkstop_o
);
  logic [N_SUB-1:0] pend_q;
  logic [N_SUB-1:0] rep_clr;
  logic             take_exig;
  logic             exig_pend;
  logic             dmg_pend;

  mc_pend_bank #(.N_SUB(N_SUB)) bank_i (
    .clk(clk), .rst(rst), .set_i(rep_cond_i), .clr_i(rep_clr), .pend_o(pend_q)
  );

  mc_dmg_guard guard_i (
    .clk(clk), .rst(rst), .exig_cond_i(exig_cond_i), .damage_i(damage_i),
    .glob_en_i(glob_en_i), .take_exig_i(take_exig), .exig_pend_o(exig_pend),
    .dmg_pend_o(dmg_pend), .chkstop_o(chkstop_o)
  );

  mc_req_arb #(.N_SUB(N_SUB)) arb_i (
    .clk(clk), .rst(rst), .pend_i(pend_q), .mask_i(sub_mask_i),
    .glob_en_i(glob_en_i), .bound_i(insn_bound_i), .busy_i(mfunc_busy_i),
    .exig_pend_i(exig_pend), .dmg_pend_i(dmg_pend), .stopped_i(chkstop_o),
    .take_exig_o(take_exig), .rep_clr_o(rep_clr), .req_o(mc_req_o),
    .kind_o(mc_exig_o), .suppress_o(suppress_o), .code_sub_o(code_sub_o),
    .code_dmg_o(code_dmg_o)
  );
endmodule

// File: rtl/mc_cond_ctrl_chk.sv
module mc_cond_ctrl_chk #(
  parameter int N_SUB = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SUB-1:0] rep_cond_i,
  input logic             glob_en_i,
  input logic [N_SUB-1:0] sub_mask_i,
  input logic             insn_bound_i,
  input logic             mfunc_busy_i,
  input logic             mc_req_o,
  input logic             mc_exig_o,
  input logic             suppress_o,
  input logic [N_SUB-1:0] code_sub_o,
  input logic             code_dmg_o,
  input logic             chkstop_o,
  input logic [N_SUB-1:0] pend_q
);
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mc_req_o |-> $past(glob_en_i)); // R1

  AST_REP_MASK_HIT: assert property (@(posedge clk) disable iff (rst)
    (mc_req_o && !mc_exig_o) |-> (|($past(pend_q) & $past(sub_mask_i)))); // R1

  AST_REP_AT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (mc_req_o && !mc_exig_o) |-> ($past(insn_bound_i) && !$past(mfunc_busy_i))); // R4

  AST_REP_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (mc_req_o && !mc_exig_o) |-> ((pend_q & code_sub_o) == ($past(rep_cond_i) & code_sub_o))); // R5

  AST_EXIG_NO_SUB: assert property (@(posedge clk) disable iff (rst)
    (mc_req_o && mc_exig_o) |-> (code_sub_o == '0 && suppress_o)); // R6

  AST_DMG_IS_EXIG: assert property (@(posedge clk) disable iff (rst)
    code_dmg_o |-> (mc_req_o && mc_exig_o)); // R9

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(chkstop_o) |-> chkstop_o); // R8

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(chkstop_o) && chkstop_o) |-> !mc_req_o); // R8
endmodule

bind mc_cond_ctrl mc_cond_ctrl_chk #(.N_SUB(N_SUB)) chk_i (
  .clk(clk), .rst(rst), .rep_cond_i(rep_cond_i), .glob_en_i(glob_en_i),
  .sub_mask_i(sub_mask_i), .insn_bound_i(insn_bound_i),
  .mfunc_busy_i(mfunc_busy_i), .mc_req_o(mc_req_o), .mc_exig_o(mc_exig_o),
  .suppress_o(suppress_o), .code_sub_o(code_sub_o), .code_dmg_o(code_dmg_o),
  .chkstop_o(chkstop_o), .pend_q(pend_q)
);

// File: tb/mc_cond_ctrl_tb_top.sv
module mc_cond_ctrl_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] rep_cond, mask, code_sub;
  logic exig, dmg, gen, bnd, busy;
  logic req, kind, supp, cdmg, stop;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  mc_cond_ctrl #(.N_SUB(N)) dut_i (
    .clk(clk), .rst(rst), .rep_cond_i(rep_cond), .exig_cond_i(exig),
    .damage_i(dmg), .glob_en_i(gen), .sub_mask_i(mask),
    .insn_bound_i(bnd), .mfunc_busy_i(busy), .mc_req_o(req),
    .mc_exig_o(kind), .suppress_o(supp), .code_sub_o(code_sub),
    .code_dmg_o(cdmg), .chkstop_o(stop)
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rep_cond = '0; mask = '0; exig = 0; dmg = 0; gen = 1; bnd = 0; busy = 0;
    tick(); tick(); tick();
    rst = 1'b0;
  endtask

  task automatic chk_rep(input string tag, input logic [N-1:0] code);
    check({tag, " req"}, req, 1);
    check({tag, " kind"}, kind, 0);
    check({tag, " supp"}, supp, 0);
    check({tag, " code"}, code_sub, code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    check("R9 reset req", req, 0);
    check("R9 reset stop", stop, 0);
    check("R9 reset code", {23'd0, code_sub, cdmg}, 0);

    // R1 R5 sweep: every mask value against a distinct pending pattern
    for (int m = 0; m < 256; m++) begin
      logic [N-1:0] p;
      p = N'((m * 37 + 11) & 255);
      if (p == 0) p = 1;
      rep_cond = p; mask = '0; bnd = 0; tick();
      rep_cond = '0; mask = N'(m); bnd = 1; tick();
      if ((p & N'(m)) != 0) begin
        chk_rep("R5 sweep", p);
        bnd = 0; tick();
        check("R9 pulse", req, 0);
      end else begin
        check("R1 masked", req, 0);
        mask = '1; tick();
        chk_rep("R3 drain", p);
        bnd = 0; tick();
      end
    end

    // R3 repeated pulses, masked, collapse to one
    mask = '0; bnd = 1;
    for (int k = 0; k < 3; k++) begin
      rep_cond = 8'h04; tick(); rep_cond = '0; tick();
    end
    check("R3 held", req, 0);
    mask = 8'h04; tick();
    chk_rep("R3 single", 8'h04);
    tick();
    check("R3 no second", req, 0);

    // R4 boundary and busy
    bnd = 0; rep_cond = 8'h10; mask = 8'h10; tick(); rep_cond = '0;
    tick(); check("R4 no bound", req, 0);
    bnd = 1; busy = 1; tick(); check("R4 busy", req, 0);
    tick(); check("R4 busy2", req, 0);
    busy = 0; tick(); chk_rep("R4 free", 8'h10);

    // R1 global enable off
    gen = 0; rep_cond = 8'h01; mask = '1; tick(); rep_cond = '0;
    tick(); check("R1 gen off", req, 0);
    gen = 1; tick(); chk_rep("R1 gen on", 8'h01);

    // R2 exigent ignores bound, busy, mask
    bnd = 0; busy = 1; mask = '0; exig = 1; tick(); exig = 0; tick();
    check("R2 req", req, 1); check("R2 kind", kind, 1);
    check("R6 supp", supp, 1); check("R9 no dmg", cdmg, 0);
    busy = 0;
    gen = 0; exig = 1; tick(); exig = 0; tick(); tick();
    check("R2 held", req, 0);
    gen = 1; tick(); check("R2 released", req, 1);

    // R6 priority
    gen = 0; mask = 8'h01; rep_cond = 8'h01; exig = 1; tick();
    rep_cond = '0; exig = 0; gen = 1; bnd = 1; tick();
    check("R6 first kind", kind, 1); check("R6 first req", req, 1);
    check("R6 first code", code_sub, 0);
    tick(); chk_rep("R6 second", 8'h01);

    // R7 same-cycle arrival at clear
    bnd = 0; mask = 8'h08; rep_cond = 8'h08; tick();
    bnd = 1; tick(); rep_cond = '0;
    chk_rep("R7 first", 8'h08);
    bnd = 0; tick(); check("R7 gap", req, 0);
    bnd = 1; tick(); chk_rep("R7 again", 8'h08);
    bnd = 0;

    // R10 guard release
    dmg = 1; tick(); dmg = 0; tick();
    check("R9 dmg req", req, 1); check("R9 dmg code", cdmg, 1);
    gen = 0; tick(); gen = 1; tick();
    gen = 0; dmg = 1; tick(); dmg = 0;
    check("R10 no stop", stop, 0);
    gen = 1; tick(); check("R10 pending dmg", {req, kind, cdmg}, 3'b111);

    // R8 check-stop
    gen = 0; dmg = 1; tick(); dmg = 0;
    check("R8 stop", stop, 1);
    gen = 1; mask = '1; bnd = 1; rep_cond = 8'h02; tick(); rep_cond = '0;
    tick(); check("R8 silent", req, 0);
    tick(); check("R8 sticky", stop, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule